// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block collects a set of peripheral interrupt lines and presents them to several processor cores. Each line can be level or edge sensitive, with a chosen active sense. Each line has an enable bit, changed through separate set and clear registers. Each line also has a route byte that picks which cores see it and which of the parent interrupt outputs it drives on those cores. Edge events are captured in a per-line latch. Software clears the latch through the same register that clears the enable bit.

A simple synchronous register bus writes bytes or words and reads words. Each core gets a vector of parent interrupt outputs and its own view of the pending-and-enabled lines, filtered by the route bytes. A combined status word can also be read over the bus.

Top module: `routed_irq_ctrl`

## Requirements
- R1: After reset, the enable mask, the polarity word, the mode word and every route byte read as zero, and `core_irq` and `core_pend` are all zero.
- R2: A byte write to offset i (0x00 up to the last source) replaces route byte i with `bus_wdata[7:0]`. A word write to a 4-aligned offset in the route region replaces four route bytes, with the lowest data byte going to the lowest offset. A word read of that region returns the bytes in the same order.
- R3: A word write to 0x28 sets every enable bit whose data bit is 1 and leaves the rest unchanged. The word at 0x24 reads the enable mask.
- R4: A word write to 0x2C clears every enable bit whose data bit is 1 and leaves the rest unchanged.
- R5: Bit i of the word at 0x30 is the polarity (1 = active high or rising, 0 = active low or falling). A line whose bit in the mode word at 0x34 is 0 is level sensitive: it is pending exactly while its input equals the active level.
- R6: A line whose mode bit is 1 latches a pending bit on its selected edge, whether or not it is enabled. The latch holds after the input returns. It clears only when a 1 is written to that line's bit at 0x2C. When an edge and such a clear fall in the same cycle, the latch stays set.
- R7: The word at 0x40 reads, for each line, its pending bit ANDed with its enable bit.
- R8: Bit i of core c's slice of `core_pend` (bits c*NUM_SRC+i) is set only when line i is pending, enabled, and has bit c (c in 0..3) of its route byte set.
- R9: `core_irq` bit c*NUM_PAR+n is set exactly when some pending, enabled line has both route bit c and route bit 4+n set.
- R10: Word reads at 0x20, 0x28, 0x2C and any other unmapped offset return zero. Writes to unmapped offsets, byte writes outside the route region, and word writes whose address is not 4-aligned change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_word | input | 1 | 1 = word access, 0 = byte access (data in bits 7:0) |
| bus_addr | input | 8 | Byte offset; reads use the 4-aligned word containing it |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data appears on the next cycle |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd`, else zero |
| irq_in | input | NUM_SRC | Interrupt lines, already synchronous to `clk` |
| core_irq | output | NUM_CORE*NUM_PAR | Parent outputs, core-major, registered |
| core_pend | output | NUM_CORE*NUM_SRC | Per-core pending view, core-major, registered |

## Verification
The bench builds the block with its defaults: 32 lines, four cores and four parent outputs. This makes every route byte offset, every core-select bit and every parent-select bit reachable at the full address map. With 32 lines the route region fills 0x00 through 0x1F exactly, so the last byte (offset 0x1F) and the first unmapped word (0x20) sit next to each other and can both be exercised. The directed tasks cover both polarities in both trigger modes. They also cover routing of one line to several cores at once and the collision of an edge with a clear in the same cycle.

// File: rtl/rlic_pkg.sv
package rlic_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 8;

    // register offsets; software depends on these positions
    localparam logic [ADDR_W-1:0] OFS_EN_MASK = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_POL     = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MODE    = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h40;

    localparam int ROUTE_W      = 8;
    localparam int ROUTE_PAR_LO = 4;

    // route byte: upper nibble picks parent outputs, lower nibble picks cores
    typedef struct packed {
        logic [3:0] par_sel;
        logic [3:0] core_sel;
    } route_t;

    typedef enum logic {
        ACC_BYTE = 1'b0,
        ACC_WORD = 1'b1
    } acc_e;

    function automatic logic [ADDR_W-1:0] word_base(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:2], 2'b00};
    endfunction

    function automatic int route_span(input int nsrc);
        return ((nsrc + 3) / 4) * 4;
    endfunction

endpackage

// File: rtl/rlic_trigger.sv
module rlic_trigger
    import rlic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] mode,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] pend
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic prev_q;
        logic latch_q;
        logic level_act;
        logic edge_hit;

        assign level_act = pol[i] ? irq_in[i] : ~irq_in[i];
        assign edge_hit  = pol[i] ? (irq_in[i] & ~prev_q) : (~irq_in[i] & prev_q);

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q  <= 1'b0;
                latch_q <= 1'b0;
            end else begin
                prev_q <= irq_in[i];
                if (!mode[i]) begin
                    latch_q <= 1'b0;
                end else if (edge_hit) begin
                    latch_q <= 1'b1;   // a new edge beats a same-cycle clear
                end else if (clr[i]) begin
                    latch_q <= 1'b0;
                end
            end
        end

        assign pend[i] = mode[i] ? latch_q : level_act;
    end

endmodule

// File: rtl/rlic_regs.sv
module rlic_regs
    import rlic_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic                       bus_word,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    input  logic                       bus_rd,
    input  logic [NUM_SRC-1:0]         pend,
    output logic [NUM_SRC-1:0]         en_q,
    output logic [NUM_SRC-1:0]         pol_q,
    output logic [NUM_SRC-1:0]         mode_q,
    output logic [NUM_SRC-1:0]         clr_hit,
    output logic [NUM_SRC*ROUTE_W-1:0] route_flat,
    output logic [WORD_W-1:0]          bus_rdata
);

    localparam int SPAN = route_span(NUM_SRC);

    acc_e size;
    logic word_ok;
    logic wr_set;
    logic wr_clr;
    logic wr_pol;
    logic wr_mode;

    assign size    = acc_e'(bus_word);
    assign word_ok = bus_wr && (size == ACC_WORD) && (bus_addr[1:0] == 2'b00);
    assign wr_set  = word_ok && (bus_addr == OFS_EN_SET);
    assign wr_clr  = word_ok && (bus_addr == OFS_EN_CLR);
    assign wr_pol  = word_ok && (bus_addr == OFS_POL);
    assign wr_mode = word_ok && (bus_addr == OFS_MODE);

    assign clr_hit = wr_clr ? bus_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pol_q  <= '0;
            mode_q <= '0;
        end else begin
            if (wr_set) en_q <= en_q | bus_wdata[NUM_SRC-1:0];
            else if (wr_clr) en_q <= en_q & ~bus_wdata[NUM_SRC-1:0];
            if (wr_pol)  pol_q  <= bus_wdata[NUM_SRC-1:0];
            if (wr_mode) mode_q <= bus_wdata[NUM_SRC-1:0];
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
        route_t route_q;
        logic   byte_hit;
        logic   word_hit;

        assign byte_hit = bus_wr && (size == ACC_BYTE) && (bus_addr == ADDR_W'(i));
        assign word_hit = word_ok && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(i / 4));

        always_ff @(posedge clk) begin
            if (rst) begin
                route_q <= '0;
            end else if (byte_hit) begin
                route_q <= route_t'(bus_wdata[7:0]);
            end else if (word_hit) begin
                route_q <= route_t'(bus_wdata[(i % 4) * 8 +: 8]);
            end
        end

        assign route_flat[i*ROUTE_W +: ROUTE_W] = route_q;
    end

    logic [ADDR_W-1:0] rd_base;
    logic [WORD_W-1:0] rd_word;

    always_comb begin
        rd_base = word_base(bus_addr);
        rd_word = '0;
        if (int'(rd_base) < SPAN) begin
            for (int j = 0; j < 4; j++) begin
                if (int'(rd_base) + j < NUM_SRC) begin
                    rd_word[j*8 +: 8] = route_flat[(int'(rd_base) + j) * ROUTE_W +: ROUTE_W];
                end
            end
        end else begin
            case (rd_base)
                OFS_EN_MASK: rd_word = WORD_W'(en_q);
                OFS_POL:     rd_word = WORD_W'(pol_q);
                OFS_MODE:    rd_word = WORD_W'(mode_q);
                OFS_STATUS:  rd_word = WORD_W'(pend & en_q);
                default:     rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= bus_rd ? rd_word : '0;
        end
    end

endmodule

// File: rtl/rlic_route.sv
module rlic_route
    import rlic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_PAR  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SRC-1:0]            pend,
    input  logic [NUM_SRC-1:0]            en,
    input  logic [NUM_SRC*ROUTE_W-1:0]    route_flat,
    output logic [NUM_CORE*NUM_PAR-1:0]   core_irq,
    output logic [NUM_CORE*NUM_SRC-1:0]   core_pend
);

    logic [NUM_SRC-1:0]          live;
    logic [NUM_SRC-1:0]          core_mask [NUM_CORE];
    logic [NUM_SRC-1:0]          par_mask  [NUM_PAR];
    logic [NUM_CORE*NUM_PAR-1:0] irq_nx;
    logic [NUM_CORE*NUM_SRC-1:0] pend_nx;

    assign live = pend & en;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_bits
        for (genvar c = 0; c < NUM_CORE; c++) begin : g_c
            assign core_mask[c][s] = route_flat[s*ROUTE_W + c];
        end
        for (genvar n = 0; n < NUM_PAR; n++) begin : g_n
            assign par_mask[n][s] = route_flat[s*ROUTE_W + ROUTE_PAR_LO + n];
        end
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        assign pend_nx[c*NUM_SRC +: NUM_SRC] = live & core_mask[c];
        for (genvar n = 0; n < NUM_PAR; n++) begin : g_par
            assign irq_nx[c*NUM_PAR + n] = |(live & core_mask[c] & par_mask[n]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_irq  <= '0;
            core_pend <= '0;
        end else begin
            core_irq  <= irq_nx;
            core_pend <= pend_nx;
        end
    end

endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl
    import rlic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_PAR  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic                        bus_word,
    input  logic [7:0]                  bus_addr,
    input  logic [31:0]                 bus_wdata,
    input  logic                        bus_rd,
    output logic [31:0]                 bus_rdata,
    input  logic [NUM_SRC-1:0]          irq_in,
    output logic [NUM_CORE*NUM_PAR-1:0] core_irq,
    output logic [NUM_CORE*NUM_SRC-1:0] core_pend
);

    logic [NUM_SRC-1:0]         en_mask;
    logic [NUM_SRC-1:0]         pol_word;
    logic [NUM_SRC-1:0]         mode_word;
    logic [NUM_SRC-1:0]         clr_hit;
    logic [NUM_SRC-1:0]         pend;
    logic [NUM_SRC*ROUTE_W-1:0] route_flat;

    rlic_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_word   (bus_word),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rd     (bus_rd),
        .pend       (pend),
        .en_q       (en_mask),
        .pol_q      (pol_word),
        .mode_q     (mode_word),
        .clr_hit    (clr_hit),
        .route_flat (route_flat),
        .bus_rdata  (bus_rdata)
    );

    rlic_trigger #(.NUM_SRC(NUM_SRC)) u_trig (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .pol    (pol_word),
        .mode   (mode_word),
        .clr    (clr_hit),
        .pend   (pend)
    );

    rlic_route #(
        .NUM_SRC  (NUM_SRC),
        .NUM_CORE (NUM_CORE),
        .NUM_PAR  (NUM_PAR)
    ) u_route (
        .clk        (clk),
        .rst        (rst),
        .pend       (pend),
        .en         (en_mask),
        .route_flat (route_flat),
        .core_irq   (core_irq),
        .core_pend  (core_pend)
    );

endmodule

// File: rtl/rlic_chk.sv
module rlic_chk
    import rlic_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CORE = 4,
    parameter int NUM_PAR  = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        bus_wr,
    input logic                        bus_word,
    input logic [7:0]                  bus_addr,
    input logic [31:0]                 bus_wdata,
    input logic                        bus_rd,
    input logic [31:0]                 bus_rdata,
    input logic [NUM_SRC-1:0]          en_mask,
    input logic [NUM_CORE*NUM_PAR-1:0] core_irq,
    input logic [NUM_CORE*NUM_SRC-1:0] core_pend
);

    localparam int SPAN = route_span(NUM_SRC);

    function automatic logic reads_zero(input logic [7:0] a);
        logic [7:0] b;
        b = word_base(a);
        return (int'(b) >= SPAN) && (b != OFS_EN_MASK) && (b != OFS_POL)
            && (b != OFS_MODE) && (b != OFS_STATUS);
    endfunction

    logic set_wr;
    logic clr_wr;
    assign set_wr = bus_wr && bus_word && (bus_addr == OFS_EN_SET);
    assign clr_wr = bus_wr && bus_word && (bus_addr == OFS_EN_CLR);

    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (core_irq == '0 && core_pend == '0 && en_mask == '0));

    assert_set_ones_R3: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> en_mask == ($past(en_mask) | $past(bus_wdata[NUM_SRC-1:0])));

    assert_mask_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !(set_wr || clr_wr) |=> $stable(en_mask));

    assert_clear_ones_R4: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> en_mask == ($past(en_mask) & ~$past(bus_wdata[NUM_SRC-1:0])));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && reads_zero(bus_addr)) |=> bus_rdata == '0);

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core_chk
        assert_core_enabled_R8: assert property (@(posedge clk) disable iff (rst)
            (core_pend[c*NUM_SRC +: NUM_SRC] & ~$past(en_mask)) == '0);

        assert_irq_backed_R9: assert property (@(posedge clk) disable iff (rst)
            (core_irq[c*NUM_PAR +: NUM_PAR] != '0) |-> (core_pend[c*NUM_SRC +: NUM_SRC] != '0));
    end

endmodule

bind routed_irq_ctrl rlic_chk #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CORE (NUM_CORE),
    .NUM_PAR  (NUM_PAR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .en_mask   (en_mask),
    .core_irq  (core_irq),
    .core_pend (core_pend)
);

// File: tb/routed_irq_ctrl_tb_top.sv
module routed_irq_ctrl_tb_top;

    localparam int NS = 32;
    localparam int NC = 4;
    localparam int NP = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bus_wr = 1'b0;
    logic             bus_word = 1'b0;
    logic [7:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic             bus_rd = 1'b0;
    logic [31:0]      bus_rdata;
    logic [NS-1:0]    irq_in = '0;
    logic [NC*NP-1:0] core_irq;
    logic [NC*NS-1:0] core_pend;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    routed_irq_ctrl #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PAR(NP)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_in(irq_in), .core_irq(core_irq),
        .core_pend(core_pend)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic word, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, 64'(d), 64'(exp));
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 core_irq", 64'(core_irq), 64'h0);
        check("R1 core_pend lo", 64'(core_pend[63:0]), 64'h0);
        check("R1 core_pend hi", 64'(core_pend[127:64]), 64'h0);
        rd_check("R1 enable mask", 8'h24, 32'h0);
        rd_check("R1 polarity", 8'h30, 32'h0);
        rd_check("R1 mode", 8'h34, 32'h0);
        rd_check("R1 route 0x00", 8'h00, 32'h0);
        rd_check("R1 route 0x1C", 8'h1C, 32'h0);
    endtask

    task automatic t_route();
        wr(1'b0, 8'h05, 32'hFFFF_FFA3);
        rd_check("R2 byte write", 8'h04, 32'h0000_A300);
        wr(1'b1, 8'h1C, 32'h4433_2211);
        rd_check("R2 word write", 8'h1C, 32'h4433_2211);
        wr(1'b0, 8'h1F, 32'h0000_0081);
        rd_check("R2 top byte", 8'h1C, 32'h8133_2211);
        wr(1'b1, 8'h04, 32'h0);
        wr(1'b1, 8'h1C, 32'h0);
        rd_check("R2 word clear", 8'h04, 32'h0);
    endtask

    task automatic t_enable();
        wr(1'b1, 8'h28, 32'h0000_00F0);
        rd_check("R3 set", 8'h24, 32'h0000_00F0);
        wr(1'b1, 8'h28, 32'h0000_000F);
        rd_check("R3 set merges", 8'h24, 32'h0000_00FF);
        wr(1'b1, 8'h2C, 32'h0000_0030);
        rd_check("R4 clear", 8'h24, 32'h0000_00CF);
        wr(1'b1, 8'h28, 32'h0);
        rd_check("R3 zero set", 8'h24, 32'h0000_00CF);
        wr(1'b1, 8'h2C, 32'h0);
        rd_check("R4 zero clear", 8'h24, 32'h0000_00CF);
        wr(1'b1, 8'h2C, 32'hFFFF_FFFF);
        rd_check("R4 clear all", 8'h24, 32'h0);
    endtask

    task automatic t_level();
        wr(1'b0, 8'h03, 32'h21);          // core 0, parent 1
        wr(1'b1, 8'h30, 32'h8);           // source 3 active high
        wr(1'b1, 8'h28, 32'h8);
        settle();
        check("R5 inactive high", 64'(core_irq), 64'h0);
        irq_in[3] = 1'b1;
        settle();
        check("R9 level high irq", 64'(core_irq), 64'h0002);
        check("R8 level core0", 64'(core_pend[31:0]), 64'h8);
        check("R8 other cores", 64'(core_pend[127:32]), 64'h0);
        rd_check("R7 status level", 8'h40, 32'h8);
        irq_in[3] = 1'b0;
        settle();
        check("R5 level drops", 64'(core_irq), 64'h0);
        wr(1'b1, 8'h30, 32'h0);           // active low
        settle();
        check("R5 active low", 64'(core_irq), 64'h0002);
        irq_in[3] = 1'b1;
        settle();
        check("R5 low released", 64'(core_irq), 64'h0);
        irq_in[3] = 1'b0;
        wr(1'b0, 8'h03, 32'h18);          // core 3, parent 0
        settle();
        check("R9 reroute", 64'(core_irq), 64'h1000);
        check("R8 reroute core3", 64'(core_pend[127:96]), 64'h8);
        check("R8 reroute core0", 64'(core_pend[31:0]), 64'h0);
        wr(1'b1, 8'h2C, 32'h8);
        settle();
        check("R4 disable quiets", 64'(core_irq), 64'h0);
        rd_check("R7 status disabled", 8'h40, 32'h0);
    endtask

    task automatic t_edge();
        wr(1'b1, 8'h34, 32'h80);
        wr(1'b1, 8'h30, 32'h80);          // rising
        wr(1'b0, 8'h07, 32'h86);          // cores 1,2 parent 3
        @(negedge clk); irq_in[7] = 1'b1;
        @(negedge clk); irq_in[7] = 1'b0;
        settle();
        check("R6 disabled no irq", 64'(core_irq), 64'h0);
        wr(1'b1, 8'h28, 32'h80);
        settle();
        check("R6 latched while disabled", 64'(core_irq), 64'h0880);
        check("R8 edge core1", 64'(core_pend[63:32]), 64'h80);
        check("R8 edge core2", 64'(core_pend[95:64]), 64'h80);
        check("R8 edge core0", 64'(core_pend[31:0]), 64'h0);
        rd_check("R7 status edge", 8'h40, 32'h80);
        wr(1'b1, 8'h2C, 32'h80);
        wr(1'b1, 8'h28, 32'h80);
        settle();
        rd_check("R6 cleared latch", 8'h40, 32'h0);
        check("R6 cleared irq", 64'(core_irq), 64'h0);
        wr(1'b1, 8'h30, 32'h0);           // falling
        @(negedge clk); irq_in[7] = 1'b1;
        settle();
        rd_check("R6 rise ignored", 8'h40, 32'h0);
        @(negedge clk); irq_in[7] = 1'b0;
        settle();
        rd_check("R6 falling latch", 8'h40, 32'h80);
        wr(1'b1, 8'h2C, 32'h80);
        @(negedge clk); irq_in[7] = 1'b1;
        settle();
        @(negedge clk);
        irq_in[7] = 1'b0;
        bus_wr = 1'b1; bus_word = 1'b1; bus_addr = 8'h2C; bus_wdata = 32'h80;
        @(negedge clk);
        bus_wr = 1'b0;
        wr(1'b1, 8'h28, 32'h80);
        settle();
        rd_check("R6 edge beats clear", 8'h40, 32'h80);
        wr(1'b1, 8'h2C, 32'hFFFF_FFFF);
    endtask

    task automatic t_unmapped();
        wr(1'b1, 8'h28, 32'h11);
        wr(1'b1, 8'h30, 32'h5);
        wr(1'b1, 8'h34, 32'h2);
        wr(1'b1, 8'h00, 32'h0403_0201);
        rd_check("R10 read 0x20", 8'h20, 32'h0);
        rd_check("R10 read 0x2C", 8'h2C, 32'h0);
        rd_check("R10 read 0x28", 8'h28, 32'h0);
        rd_check("R10 read 0x50", 8'h50, 32'h0);
        wr(1'b1, 8'h50, 32'hFFFF_FFFF);
        wr(1'b0, 8'h28, 32'hFF);
        wr(1'b1, 8'h29, 32'hFFFF_FFFF);
        wr(1'b0, 8'h30, 32'hFF);
        wr(1'b1, 8'h01, 32'hFFFF_FFFF);
        rd_check("R10 enable kept", 8'h24, 32'h11);
        rd_check("R10 polarity kept", 8'h30, 32'h5);
        rd_check("R10 mode kept", 8'h34, 32'h2);
        rd_check("R10 route kept", 8'h00, 32'h0403_0201);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_route();
        t_enable();
        t_level();
        t_edge();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule